// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Controller

This block sits between a synchronous host and an external pseudo-static RAM of 1M x 16 bits that has an SRAM-like pin set. The host issues one request at a time: an address, a read/write flag, write data and a two-bit byte mask. The controller drives the chip enables, write strobe, output enable, the two byte strobes and the address. It runs each access for a fixed number of clock cycles and then returns one done pulse. For reads, that pulse comes with the captured data.

Every analog timing limit becomes a cycle count when the design is elaborated, using the clock period parameter. The minimums round up and the write-pulse ceiling rounds down. The data bus is exposed as a split output/enable/input triple, so a pad ring or board-level tristate can be attached. A sleep input parks the memory in deep power-down through an active-low sleep pin. Sleep is entered only between accesses, and host requests are held off until the memory has been woken again.

Top module: `psram_ctrl`

## Requirements
- R1: While rst_ni is low, mem_ce1_no, mem_we_no, mem_oe_no, mem_ub_no, mem_lb_no and mem_zz_no are 1, and mem_dq_oe_o and done_o are 0.
- R2: A request is taken only on a clock edge where req_i and ready_o are both 1. ready_o stays 0 from that edge until the access ends. Each taken request yields exactly one done_o pulse, one cycle long.
- R3: A read holds mem_ce1_no and mem_oe_no at 0 with mem_we_no at 1 for at least 85 ns. The data is captured at the end of that window, so it is valid no earlier than 85 ns after the address and 15 ns after output enable. rdata_o shows it while done_o is 1.
- R4: A write holds mem_we_no at 0 for at least 65 ns and at most 30,000 ns. Throughout the pulse, mem_oe_no is 1 and mem_dq_oe_o is 1. mem_dq_o is stable for at least 25 ns before mem_we_no rises and is still driven on that edge.
- R5: be_i[1] selects bits 15:8 via mem_ub_no = 0, and be_i[0] selects bits 7:0 via mem_lb_no = 0. A write changes only the selected bytes. A read returns 0 in the bits of unselected bytes.
- R6: A request with be_i = 2'b00 keeps mem_ce1_no, mem_we_no and mem_oe_no at 1 and never drives the bus. It still completes with done_o after the normal latency.
- R7: rdata_o keeps the value from the last read's done pulse until the next read completes.
- R8: mem_dq_oe_o does not rise until at least 20 ns after mem_oe_no has risen.
- R9: mem_zz_no goes to 0 only when no access is in progress. While it is 0, or while sleep_req_i is 1, ready_o is 0. After sleep_req_i falls, mem_zz_no returns to 1 one cycle before ready_o returns to 1.
- R10: mem_addr_o equals the accepted address from the edge that accepts the request until the access ends, with no change while mem_ce1_no is 0.
- R11: With a clock period of T ns, done_o appears ceil(85/T)+1 cycles after the accepting edge for reads, writes and empty-mask requests. At 50 MHz this is 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte mask, bit 1 = upper byte |
| sleep_req_i | input | 1 | Deep power-down request |
| ready_o | output | 1 | Request can be taken this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, held until the next read completes |
| mem_ce1_no | output | 1 | Chip enable, active low |
| mem_ce2_o | output | 1 | Second chip enable, held high |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_ub_no | output | 1 | Upper byte strobe, active low |
| mem_lb_no | output | 1 | Lower byte strobe, active low |
| mem_zz_no | output | 1 | Deep-sleep pin, active low |
| mem_addr_o | output | 20 | Memory address |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data returned by the memory |

## Verification
The assertions rely on a few host-side conditions. req_i is only meaningful while ready_o is 1. sleep_req_i is a level held for several cycles. The clock period parameter matches the actual clock, so cycle counts stand in for nanoseconds. The stimulus drives req_i for exactly one accepting cycle and waits for ready_o before each request. It raises sleep only from idle or in the middle of a single access. A bench memory model measures the analog windows in real time and returns garbage if data is sampled too early.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_RD_END, ST_WR, ST_WR_END, ST_SLEEP, ST_WAKE
  } st_e;

  function automatic int unsigned ns2cyc_up(int unsigned ns, int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned ns2cyc_dn(int unsigned ns, int unsigned clk_ps);
    return (ns * 1000) / clk_ps;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_timer.sv
module psram_timer #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/psram_lane.sv
module psram_lane #(
  parameter int unsigned LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          en_i,
  input  logic [LW-1:0] din_i,
  output logic [LW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= en_i ? din_i : '0;
  end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CLK_PS      = 20000,
  parameter int unsigned T_CYC_NS    = 85,
  parameter int unsigned T_WP_MIN_NS = 65,
  parameter int unsigned T_WP_MAX_NS = 30000,
  parameter int unsigned T_DW_NS     = 25,
  parameter int unsigned T_OE_NS     = 15,
  parameter int unsigned T_HZ_NS     = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        be_i,
  input  logic              sleep_req_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_ce1_no,
  output logic              mem_ce2_o,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic              mem_ub_no,
  output logic              mem_lb_no,
  output logic              mem_zz_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned LANES      = DATA_W / 8;
  localparam int unsigned CYC_CYC    = umax(ns2cyc_up(T_CYC_NS, CLK_PS), 1);
  localparam int unsigned RD_CYC     = umax(CYC_CYC, ns2cyc_up(T_OE_NS, CLK_PS));
  localparam int unsigned WP_MIN_CYC = umax(ns2cyc_up(T_WP_MIN_NS, CLK_PS), 1);
  localparam int unsigned WP_MAX_CYC = ns2cyc_dn(T_WP_MAX_NS, CLK_PS);
  localparam int unsigned WE_CYC     = umax(umax(WP_MIN_CYC, ns2cyc_up(T_DW_NS, CLK_PS)), CYC_CYC);
  localparam int unsigned HZ_CYC     = umax(ns2cyc_up(T_HZ_NS, CLK_PS), 1);
  localparam int unsigned CNT_MAX    = umax(umax(RD_CYC, WE_CYC), HZ_CYC);
  localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1);

  st_e               st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        be_q;
  logic              done_q;
  logic              ld, cap, acc, t_zero;
  logic [CNT_W-1:0]  ld_val;

  psram_timer #(.W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ld_val),
    .zero_o (t_zero)
  );

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    cap    = 1'b0;
    acc    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (sleep_req_i) st_d = ST_SLEEP;
        else if (req_i) begin
          acc = 1'b1;
          ld  = 1'b1;
          if (we_i) begin
            st_d   = ST_WR;
            ld_val = CNT_W'(WE_CYC - 1);
          end else begin
            st_d   = ST_RD;
            ld_val = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_RD: if (t_zero) begin
        st_d   = ST_RD_END;
        cap    = 1'b1;
        ld     = 1'b1;
        ld_val = CNT_W'(HZ_CYC - 1);  // bus turnaround before next drive
      end
      ST_RD_END: if (t_zero) st_d = ST_IDLE;
      ST_WR:     if (t_zero) st_d = ST_WR_END;
      ST_WR_END: st_d = ST_IDLE;
      ST_SLEEP:  if (!sleep_req_i) st_d = ST_WAKE;
      ST_WAKE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= t_zero && (st_q == ST_RD || st_q == ST_WR);
      if (acc) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        be_q    <= be_i;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    psram_lane #(.LW(8)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (cap),
      .en_i   (be_q[g]),
      .din_i  (mem_dq_i[g*8 +: 8]),
      .q_o    (rdata_o[g*8 +: 8])
    );
  end

  // pin decode from state flops; an empty mask keeps the chip in standby
  logic act, sel;
  assign act = |be_q;
  assign sel = (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_WR_END);

  assign mem_ce1_no  = !(act && sel);
  assign mem_ce2_o   = 1'b1;
  assign mem_oe_no   = !(act && st_q == ST_RD);
  assign mem_we_no   = !(act && st_q == ST_WR);
  assign mem_ub_no   = !(be_q[1] && sel);
  assign mem_lb_no   = !(be_q[0] && sel);
  assign mem_zz_no   = (st_q != ST_SLEEP);
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = act && (st_q == ST_WR || st_q == ST_WR_END);
  assign ready_o     = (st_q == ST_IDLE) && !sleep_req_i;
  assign done_o      = done_q;
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned WP_MIN_CYC = 4,
  parameter int unsigned WP_MAX_CYC = 1500,
  parameter int unsigned HZ_CYC     = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sleep_req_i,
  input logic              ready_o,
  input logic              done_o,
  input logic              mem_ce1_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic              mem_ub_no,
  input logic              mem_lb_no,
  input logic              mem_zz_no,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_dq_oe_o
);
  localparam int unsigned WC_W = $clog2(WP_MAX_CYC + 2);
  localparam int unsigned HC_W = $clog2(HZ_CYC + 1);

  logic [WC_W-1:0] we_cnt;
  logic [HC_W-1:0] hz_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_cnt <= '0;
      hz_cnt <= HC_W'(HZ_CYC);
    end else begin
      if (!mem_we_no) begin
        if (we_cnt != WC_W'(WP_MAX_CYC + 1)) we_cnt <= we_cnt + 1'b1;
      end else we_cnt <= '0;
      if (!mem_oe_no) hz_cnt <= '0;
      else if (hz_cnt != HC_W'(HZ_CYC)) hz_cnt <= hz_cnt + 1'b1;
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_we_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (we_cnt >= WC_W'(WP_MIN_CYC)));
  p_we_max_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (we_cnt < WC_W'(WP_MAX_CYC)));
  p_we_oe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_oe_no && mem_dq_oe_o));
  p_standby_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ub_no && mem_lb_no) |-> (mem_ce1_no && mem_we_no && mem_oe_no && !mem_dq_oe_o));
  p_turn_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (hz_cnt >= HC_W'(HZ_CYC)));
  p_zz_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_zz_no |-> (mem_ce1_no && mem_we_no && mem_oe_no && !mem_dq_oe_o));
  p_sleep_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_req_i || !mem_zz_no) |-> !ready_o);
  p_addr_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce1_no && $past(!mem_ce1_no)) |-> $stable(mem_addr_o));
endmodule

bind psram_ctrl psram_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .WP_MIN_CYC (WP_MIN_CYC),
  .WP_MAX_CYC (WP_MAX_CYC),
  .HZ_CYC     (HZ_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sleep_req_i (sleep_req_i),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .mem_ce1_no  (mem_ce1_no),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_ub_no   (mem_ub_no),
  .mem_lb_no   (mem_lb_no),
  .mem_zz_no   (mem_zz_no),
  .mem_addr_o  (mem_addr_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/psram_ctrl_tb_top.sv
`timescale 1ns/1ps
module psram_ctrl_tb_top;
  localparam int LAT = (85 * 1000 + 20000 - 1) / 20000 + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, sleep = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic        ready_o, done_o;
  logic [15:0] rdata_o;
  logic        mem_ce1_no, mem_ce2_o, mem_we_no, mem_oe_no, mem_ub_no, mem_lb_no, mem_zz_no;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_dq_o, dq_in;
  logic        mem_dq_oe_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  psram_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .sleep_req_i(sleep), .ready_o(ready_o),
    .done_o(done_o), .rdata_o(rdata_o), .mem_ce1_no(mem_ce1_no),
    .mem_ce2_o(mem_ce2_o), .mem_we_no(mem_we_no), .mem_oe_no(mem_oe_no),
    .mem_ub_no(mem_ub_no), .mem_lb_no(mem_lb_no), .mem_zz_no(mem_zz_no),
    .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
    .mem_dq_i(dq_in)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory model, 256 words aliased on addr[7:0]
  logic [15:0] mdl_mem [256];
  logic [15:0] exp_mem [256];
  realtime t_addr = 0, t_oe = 0, t_we = 0, t_dq = 0, t_oe_rise = 0;
  bit we_fell = 0, oe_rose = 0, we_viol = 0;
  logic [19:0] cur_addr = '0;

  function automatic logic [15:0] lane_mask(logic [1:0] b);
    return {{8{b[1]}}, {8{b[0]}}};
  endfunction

  always @(mem_addr_o) t_addr = $realtime;
  always @(negedge mem_oe_no) t_oe = $realtime;
  always @(posedge mem_oe_no) if (t_oe > 0) begin t_oe_rise = $realtime; oe_rose = 1; end
  always @(mem_dq_o) t_dq = $realtime;
  always @(negedge mem_we_no) begin t_we = $realtime; we_fell = 1; we_viol = 0; end

  always @(posedge mem_we_no) if (we_fell) begin
    we_fell = 0;
    chk(($realtime - t_we) >= 65.0 && ($realtime - t_we) <= 30000.0, "R4 pulse width",
        32'($rtoi($realtime - t_we)), 32'd65);
    chk(($realtime - t_dq) >= 25.0, "R4 data setup", 32'($rtoi($realtime - t_dq)), 32'd25);
    chk(!we_viol && mem_dq_oe_o, "R4 oe/drive during pulse", {31'd0, we_viol}, 32'd0);
    chk(mem_addr_o == cur_addr, "R10 write address", 32'(mem_addr_o), 32'(cur_addr));
    if (!mem_ce1_no && mem_ce2_o) begin
      if (!mem_ub_no) mdl_mem[mem_addr_o[7:0]][15:8] = mem_dq_o[15:8];
      if (!mem_lb_no) mdl_mem[mem_addr_o[7:0]][7:0]  = mem_dq_o[7:0];
    end
  end

  always @(posedge mem_dq_oe_o) if (oe_rose)
    chk(($realtime - t_oe_rise) >= 20.0, "R8 turnaround", 32'($rtoi($realtime - t_oe_rise)), 32'd20);

  initial begin
    dq_in = 16'hC3C3;
    #0.5;
    forever begin
      #1;
      if (!mem_we_no && (!mem_oe_no || !mem_dq_oe_o)) we_viol = 1;
      if (mem_ce2_o && !mem_ce1_no && !mem_oe_no && mem_we_no) begin
        logic [15:0] v;
        v = mdl_mem[mem_addr_o[7:0]];
        if (($realtime - t_addr) < 85.0 || ($realtime - t_oe) < 15.0) v = 16'hBAD0;
        if (mem_ub_no) v[15:8] = 8'hA5;
        if (mem_lb_no) v[7:0] = 8'h5A;
        dq_in = v;
      end else dq_in = 16'hC3C3;
    end
  end

  logic [15:0] last_rd = '0;

  task automatic do_req(bit w, logic [19:0] a, logic [15:0] d, logic [1:0] b);
    int n;
    bit saw_ce;
    logic [15:0] e;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    chk(rdata_o == last_rd, "R7 read data held", 32'(rdata_o), 32'(last_rd));
    req = 1; we = w; addr = a; wdata = d; be = b;
    @(posedge clk);
    cur_addr = a;
    @(negedge clk);
    req = 0; wdata = ~d;
    chk(!ready_o, "R2 ready low in access", {31'd0, ready_o}, 32'd0);
    n = 1; saw_ce = 0;
    while (!done_o && n < 40) begin
      if (!mem_ce1_no) saw_ce = 1;
      @(negedge clk); n++;
    end
    chk(n == LAT, "R11 latency", 32'(n), 32'(LAT));
    chk(mem_addr_o == a, "R10 address held", 32'(mem_addr_o), 32'(a));
    if (b == 2'b00) chk(!saw_ce, "R6 empty mask standby", {31'd0, saw_ce}, 32'd0);
    if (!w) begin
      e = exp_mem[a[7:0]] & lane_mask(b);
      chk(rdata_o == e, "R3/R5 read data", 32'(rdata_o), 32'(e));
      last_rd = e;
    end else begin
      if (b[1]) exp_mem[a[7:0]][15:8] = d[15:8];
      if (b[0]) exp_mem[a[7:0]][7:0]  = d[7:0];
    end
    @(negedge clk);
    chk(!done_o, "R2 single done pulse", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mdl_mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
      exp_mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
    end
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({mem_ce1_no, mem_we_no, mem_oe_no, mem_ub_no, mem_lb_no, mem_zz_no} == 6'h3F,
        "R1 reset strobes", 32'({mem_ce1_no, mem_we_no, mem_oe_no, mem_ub_no, mem_lb_no, mem_zz_no}), 32'h3F);
    chk(!mem_dq_oe_o && !done_o, "R1 reset bus/done", {30'd0, mem_dq_oe_o, done_o}, 32'd0);
    rst_n = 1;
    // directed
    do_req(1, 20'h00000, 16'h1234, 2'b11);
    do_req(0, 20'h00000, 16'h0, 2'b11);
    do_req(1, 20'h00000, 16'hAB00, 2'b10);      // R5 upper only
    do_req(0, 20'h00000, 16'h0, 2'b11);
    do_req(1, 20'h00000, 16'h00CD, 2'b01);      // R5 lower only
    do_req(0, 20'h00000, 16'h0, 2'b01);
    do_req(1, 20'h00000, 16'hFFFF, 2'b00);      // R6 empty mask write
    do_req(0, 20'h00000, 16'h0, 2'b11);
    do_req(0, 20'h00000, 16'h0, 2'b00);         // R6 empty mask read -> 0
    do_req(1, 20'hFFFFF, 16'hBEEF, 2'b11);      // top address
    do_req(0, 20'hFFFFF, 16'h0, 2'b11);
    do_req(1, 20'h00011, 16'h7777, 2'b11);      // read then write: R8
    // R9 sleep from idle
    @(negedge clk); sleep = 1;
    @(negedge clk);
    chk(!mem_zz_no && !ready_o, "R9 sleep entered", {30'd0, mem_zz_no, ready_o}, 32'd0);
    req = 1; we = 0; addr = 20'h5;
    repeat (4) begin
      @(negedge clk);
      chk(mem_ce1_no && !ready_o, "R9 request stalled", {30'd0, mem_ce1_no, ready_o}, 32'd2);
    end
    req = 0; sleep = 0;
    @(negedge clk);
    chk(mem_zz_no && !ready_o, "R9 wake cycle", {30'd0, mem_zz_no, ready_o}, 32'd2);
    @(negedge clk);
    chk(ready_o, "R9 ready after wake", {31'd0, ready_o}, 32'd1);
    // R9 sleep requested during an access
    req = 1; we = 0; addr = 20'h3; be = 2'b11;
    @(posedge clk);
    @(negedge clk); req = 0; sleep = 1;
    while (!done_o) begin
      chk(mem_zz_no, "R9 no sleep mid-access", {31'd0, mem_zz_no}, 32'd1);
      @(negedge clk);
    end
    last_rd = exp_mem[3];
    repeat (2) @(negedge clk);
    chk(!mem_zz_no, "R9 sleep after access", {31'd0, mem_zz_no}, 32'd0);
    sleep = 0;
    // random mix
    for (int k = 0; k < 120; k++) begin
      logic [19:0] a;
      a = {12'($urandom), 8'($urandom_range(0, 15))};
      do_req(1'($urandom), a, 16'($urandom), 2'($urandom));
    end
    repeat (3) @(negedge clk);
    chk(rdata_o == last_rd, "R7 read data held at end", 32'(rdata_o), 32'(last_rd));
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule